// File: doc/BRIEF.md
# Clocked Serial Slave Transmitter

This block sends words over a single data line, bit by bit, in time with a bit clock that an external master drives. The block makes no bit clock of its own. It samples the master's clock with the system clock, finds its edges, and steps the data line forward by one bit on each falling edge of the effective clock. The master samples each bit on the rising edge that follows. Bits leave least significant first. In nine-bit mode a ninth bit follows bit 7. That ninth bit is captured from a separate host input at the moment the word is written.

The host writes words into a holding register. If the shifter is idle, a written word goes straight into the shifter. If a word is already shifting, the new word waits in the holding register. The buffer-empty flag reads 1 whenever the holding register is free. A pending word moves into the shifter only after the master has clocked out the final bit of the current word, and the flag sets in that same cycle. The flag, gated by an interrupt enable, drives the interrupt output. Separate inputs invert the incoming clock and the outgoing data line. Transmission runs only while the port enable and the transmit enable are both set, master clocking is not selected, and both receive enables are clear.

The controller has two states. IDLE goes to SHIFT when a write is accepted. SHIFT stays in SHIFT through a handoff, which loads the next word after the last bit completes. SHIFT returns to IDLE when the last bit completes and nothing waits, or when the block is disabled.

Top module: `sst_slave_tx`

## Requirements
- R1: After reset, buf_empty=1, shift_empty=1, irq=0 with irq_en=0, and sdata_out shows the idle level.
- R2: A write while the shifter is idle loads the word into the shifter at the next clock. shift_empty drops to 0, buf_empty stays 1, and bit 0 appears on the line.
- R3: A write while a word is shifting stores the word in the holding register, and buf_empty reads 0 from the next cycle.
- R4: A pending word moves into the shifter only on the falling effective clock edge that ends the current word's last bit. buf_empty stays 0 until that edge and reads 1 from that cycle on. shift_empty reads 1 only when no word is shifting.
- R5: irq is 1 exactly when buf_empty is 1 and irq_en is 1.
- R6: Data bits leave least significant bit first. Bit 0 is driven at load. Each following bit is driven on the falling edge of the effective clock that comes after a rising edge, so the master samples on rising edges.
- R7: When nine_mode=1, each word has 9 bits. Bit 8 is the ninth_bit value captured with the write, and it is sent after bit 7.
- R8: clk_invert=1 makes a low-to-high transition of sclk_in count as the falling effective edge. The effective clock is sclk_in XOR clk_invert.
- R9: sdata_out is the internal line value XOR data_invert. The internal line value is 1 while idle.
- R10: The block is active only when port_en=1, tx_en=1, master_sel=0, rx_single_en=0 and rx_cont_en=0. While inactive, writes are ignored, the shifter returns to idle, and the holding register is emptied. Both shift_empty and buf_empty then read 1.
- R11: Suppose a write comes in the same cycle as the edge that completes a word. If a word is pending, the pending word goes to the shifter and the new word is held, so buf_empty stays 0. If nothing is pending, the new word goes straight to the shifter, so buf_empty stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk_in | input | 1 | Bit clock from the external master |
| sdata_out | output | 1 | Serial data line |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| master_sel | input | 1 | Master clocking selected (must be 0 to transmit) |
| rx_single_en | input | 1 | Single-word receive enable (must be 0) |
| rx_cont_en | input | 1 | Continuous receive enable (must be 0) |
| nine_mode | input | 1 | Nine-bit word select |
| ninth_bit | input | 1 | Ninth data bit, captured with each write |
| clk_invert | input | 1 | Invert incoming clock sense |
| data_invert | input | 1 | Invert outgoing data sense |
| irq_en | input | 1 | Interrupt enable for the buffer-empty flag |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | 8 | Word to write |
| buf_empty | output | 1 | Holding register free flag |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | No word is shifting |

## Verification
A host write can land in the same system cycle as the word-completing falling edge, which is when the controller chooses what to load into the shifter. The bench brings this about by timing the write strobe so that it is sampled on the exact clock where the synchronized falling edge is acted on. It does this once with a word already pending and once with the holding register empty. It judges the outcome from buf_empty in the next cycle and from the order of the words the master then clocks out.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } sst_state_e;
endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic invert,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;
    logic eff_now;
    logic eff_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], sclk_in};
        end
    end

    always_comb begin
        eff_now = pipe[STAGES-1] ^ invert;
        eff_old = pipe[STAGES] ^ invert;
        rise    = eff_now & ~eff_old;
        fall    = ~eff_now & eff_old;
    end
endmodule

// File: rtl/sst_hold_buf.sv
module sst_hold_buf #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         bypass,
    output logic         valid,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (!active) begin
            valid <= 1'b0;
        end else if (wr && !bypass) begin
            word  <= wdata;
            valid <= 1'b1;
        end else if (pop) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         rise,
    input  logic         fall,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         nine_mode,
    input  logic         hold_valid,
    input  logic [W-1:0] hold_word,
    output logic         pop,
    output logic         bypass,
    output logic         line_raw,
    output logic         busy
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] NB_LONG  = CW'(W);
    localparam logic [CW-1:0] NB_SHORT = CW'(W - 1);

    sst_state_e         state;
    sst_state_e         state_nx;
    logic [W-1:0]       sr;
    logic [CW-1:0]      count;
    logic [CW-1:0]      nbits;
    logic               taken;
    logic               done;
    logic               load;
    logic [W-1:0]       load_word;

    always_comb begin
        done      = (state == ST_SHIFT) && fall && taken && (count == nbits);
        pop       = active && done && hold_valid;
        bypass    = active && wr && ((state == ST_IDLE) || (done && !hold_valid));
        load      = pop || bypass;
        load_word = pop ? hold_word : wdata;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (bypass) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!active)            state_nx = ST_IDLE;
                else if (done && !load) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            count <= '0;
            nbits <= NB_SHORT;
            taken <= 1'b0;
        end else if (!active) begin
            count <= '0;
            taken <= 1'b0;
        end else if (load) begin
            sr    <= load_word;
            count <= '0;
            taken <= 1'b0;
            nbits <= nine_mode ? NB_LONG : NB_SHORT;
        end else if (state == ST_SHIFT) begin
            if (rise && !taken && (count < nbits)) begin
                taken <= 1'b1;
                count <= count + 1'b1;
            end else if (fall && taken) begin
                taken <= 1'b0;
                sr    <= sr >> 1;
            end
        end
    end

    always_comb begin
        busy     = (state == ST_SHIFT);
        line_raw = busy ? sr[0] : 1'b1;
    end
endmodule

// File: rtl/sst_slave_tx.sv
module sst_slave_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    output logic              sdata_out,
    input  logic              port_en,
    input  logic              tx_en,
    input  logic              master_sel,
    input  logic              rx_single_en,
    input  logic              rx_cont_en,
    input  logic              nine_mode,
    input  logic              ninth_bit,
    input  logic              clk_invert,
    input  logic              data_invert,
    input  logic              irq_en,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_wdata,
    output logic              buf_empty,
    output logic              irq,
    output logic              shift_empty
);
    localparam int W = DATA_W + 1;

    logic         active;
    logic         rise;
    logic         fall;
    logic         pop;
    logic         bypass;
    logic         hold_valid;
    logic [W-1:0] hold_word;
    logic [W-1:0] wr_word;
    logic         line_raw;
    logic         busy;

    always_comb begin
        active  = port_en && tx_en && !master_sel && !rx_single_en && !rx_cont_en;
        wr_word = {ninth_bit, hold_wdata};
    end

    sst_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .invert  (clk_invert),
        .rise    (rise),
        .fall    (fall)
    );

    sst_hold_buf #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .wr     (hold_wr),
        .wdata  (wr_word),
        .pop    (pop),
        .bypass (bypass),
        .valid  (hold_valid),
        .word   (hold_word)
    );

    sst_shifter #(.W(W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .rise       (rise),
        .fall       (fall),
        .wr         (hold_wr),
        .wdata      (wr_word),
        .nine_mode  (nine_mode),
        .hold_valid (hold_valid),
        .hold_word  (hold_word),
        .pop        (pop),
        .bypass     (bypass),
        .line_raw   (line_raw),
        .busy       (busy)
    );

    always_comb begin
        sdata_out   = line_raw ^ data_invert;
        buf_empty   = !hold_valid;
        irq         = buf_empty && irq_en;
        shift_empty = !busy;
    end
endmodule

// File: rtl/sst_slave_tx_chk.sv
module sst_slave_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic sdata_out,
    input logic port_en,
    input logic tx_en,
    input logic master_sel,
    input logic rx_single_en,
    input logic rx_cont_en,
    input logic data_invert,
    input logic irq_en,
    input logic hold_wr,
    input logic buf_empty,
    input logic irq,
    input logic shift_empty
);
    logic act;
    always_comb act = port_en && tx_en && !master_sel && !rx_single_en && !rx_cont_en;

    a_r2_idle_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && hold_wr && act) |=> (!shift_empty && buf_empty));

    a_r3_pending_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_empty && !buf_empty && hold_wr && act) |=> !buf_empty);

    a_r4_flag_sets_on_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) && act && $rose(buf_empty)) |-> !shift_empty);

    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);

    a_r9_idle_line_level: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> (sdata_out == !data_invert));

    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (shift_empty && buf_empty));
endmodule

bind sst_slave_tx sst_slave_tx_chk u_chk (.*);

// File: tb/tb_sst_slave_tx.sv
module tb_sst_slave_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_in = 1'b0;
    logic       sdata_out;
    logic       port_en = 1'b1;
    logic       tx_en = 1'b1;
    logic       master_sel = 1'b0;
    logic       rx_single_en = 1'b0;
    logic       rx_cont_en = 1'b0;
    logic       nine_mode = 1'b0;
    logic       ninth_bit = 1'b0;
    logic       clk_invert = 1'b0;
    logic       data_invert = 1'b0;
    logic       irq_en = 1'b0;
    logic       hold_wr = 1'b0;
    logic [7:0] hold_wdata = 8'h00;
    logic       buf_empty;
    logic       irq;
    logic       shift_empty;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    sst_slave_tx dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_out(sdata_out),
        .port_en(port_en), .tx_en(tx_en), .master_sel(master_sel),
        .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
        .nine_mode(nine_mode), .ninth_bit(ninth_bit),
        .clk_invert(clk_invert), .data_invert(data_invert), .irq_en(irq_en),
        .hold_wr(hold_wr), .hold_wdata(hold_wdata),
        .buf_empty(buf_empty), .irq(irq), .shift_empty(shift_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] d, input logic nb);
        hold_wdata = d;
        ninth_bit  = nb;
        hold_wr    = 1'b1;
        @(negedge clk);
        hold_wr    = 1'b0;
    endtask

    // master model: sample, rising edge, falling edge; optional write on the completing edge
    task automatic clock_word(input int n, output logic [8:0] got,
                              input bit late_wr, input logic [7:0] wd);
        got = '0;
        for (int i = 0; i < n; i++) begin
            got[i] = sdata_out ^ data_invert;
            sclk_in = 1'b1 ^ clk_invert;
            repeat (4) @(negedge clk);
            sclk_in = 1'b0 ^ clk_invert;
            if (late_wr && i == n - 1) begin
                repeat (2) @(negedge clk);
                hold_wdata = wd;
                hold_wr = 1'b1;
                @(negedge clk);
                hold_wr = 1'b0;
                @(negedge clk);
            end else begin
                repeat (4) @(negedge clk);
            end
        end
    endtask

    task automatic t_reset();
        check("R1 buf_empty", buf_empty, 1);
        check("R1 shift_empty", shift_empty, 1);
        check("R1 irq", irq, 0);
        check("R1 idle line", sdata_out, 1);
    endtask

    task automatic t_basic();
        logic [8:0] got;
        host_write(8'hA5, 1'b0);
        check("R2 shift_empty after idle write", shift_empty, 0);
        check("R2 buf_empty after idle write", buf_empty, 1);
        check("R2 bit0 on line", sdata_out, 1);
        clock_word(8, got, 1'b0, 8'h00);
        check("R6 lsb first word", got[7:0], 8'hA5);
        check("R4 shift_empty after word", shift_empty, 1);
    endtask

    task automatic t_back_to_back();
        logic [8:0] got;
        host_write(8'h5A, 1'b0);
        host_write(8'hC3, 1'b0);
        check("R3 flag clear with pending", buf_empty, 0);
        clock_word(7, got, 1'b0, 8'h00);
        got[7] = sdata_out;
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 flag still clear before last fall", buf_empty, 0);
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 flag set after handoff", buf_empty, 1);
        check("R4 shifter busy after handoff", shift_empty, 0);
        check("R6 first word", got[7:0], 8'h5A);
        clock_word(8, got, 1'b0, 8'h00);
        check("R4 second word", got[7:0], 8'hC3);
        check("R4 idle after second", shift_empty, 1);
    endtask

    task automatic t_nine();
        logic [8:0] got;
        nine_mode = 1'b1;
        host_write(8'h3C, 1'b1);
        nine_mode = 1'b0;
        clock_word(9, got, 1'b0, 8'h00);
        check("R7 nine-bit word", got, 9'h13C);
        check("R7 idle after ninth", shift_empty, 1);
        nine_mode = 1'b1;
        host_write(8'hFF, 1'b0);
        clock_word(9, got, 1'b0, 8'h00);
        nine_mode = 1'b0;
        check("R7 ninth zero", got, 9'h0FF);
    endtask

    task automatic t_invert();
        logic [8:0] got;
        port_en = 1'b0;
        clk_invert = 1'b1;
        data_invert = 1'b1;
        sclk_in = 1'b1;
        repeat (6) @(negedge clk);
        port_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 inverted idle level", sdata_out, 0);
        host_write(8'h96, 1'b0);
        check("R9 inverted bit0 raw", sdata_out, 1);
        clock_word(8, got, 1'b0, 8'h00);
        check("R8 inverted clock word", got[7:0], 8'h96);
        check("R8 idle after", shift_empty, 1);
        port_en = 1'b0;
        clk_invert = 1'b0;
        data_invert = 1'b0;
        sclk_in = 1'b0;
        repeat (6) @(negedge clk);
        port_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_gate();
        logic [8:0] got;
        rx_cont_en = 1'b1;
        host_write(8'h55, 1'b0);
        check("R10 write ignored shift_empty", shift_empty, 1);
        check("R10 write ignored buf_empty", buf_empty, 1);
        clock_word(2, got, 1'b0, 8'h00);
        check("R10 line idle while gated", sdata_out, 1);
        rx_cont_en = 1'b0;
        @(negedge clk);
        master_sel = 1'b1;
        host_write(8'h00, 1'b0);
        check("R10 master_sel blocks", shift_empty, 1);
        master_sel = 1'b0;
        host_write(8'h0F, 1'b0);
        host_write(8'hAA, 1'b0);
        clock_word(3, got, 1'b0, 8'h00);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 disable aborts", shift_empty, 1);
        check("R10 disable empties hold", buf_empty, 1);
        tx_en = 1'b1;
        @(negedge clk);
        clock_word(2, got, 1'b0, 8'h00);
        check("R10 nothing resumes", shift_empty, 1);
    endtask

    task automatic t_irq();
        logic [8:0] got;
        irq_en = 1'b1;
        @(negedge clk);
        check("R5 irq when empty", irq, 1);
        host_write(8'h11, 1'b0);
        host_write(8'h22, 1'b0);
        check("R5 irq low while pending", irq, 0);
        clock_word(8, got, 1'b0, 8'h00);
        check("R5 irq after handoff", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        check("R5 irq masked", irq, 0);
        clock_word(8, got, 1'b0, 8'h00);
        check("R5 second word", got[7:0], 8'h22);
    endtask

    task automatic t_collide();
        logic [8:0] got;
        host_write(8'h0F, 1'b0);
        host_write(8'hF0, 1'b0);
        clock_word(8, got, 1'b1, 8'h3A);
        check("R11 pending word moves, new held", buf_empty, 0);
        check("R11 first word", got[7:0], 8'h0F);
        clock_word(8, got, 1'b0, 8'h00);
        check("R11 pending went first", got[7:0], 8'hF0);
        check("R11 flag after second handoff", buf_empty, 1);
        clock_word(8, got, 1'b0, 8'h00);
        check("R11 held word last", got[7:0], 8'h3A);
        check("R11 idle", shift_empty, 1);
        host_write(8'h81, 1'b0);
        clock_word(8, got, 1'b1, 8'h5C);
        check("R11 bypass flag stays set", buf_empty, 1);
        check("R11 bypass shifter busy", shift_empty, 0);
        clock_word(8, got, 1'b0, 8'h00);
        check("R11 bypassed word", got[7:0], 8'h5C);
        check("R11 idle after bypass", shift_empty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_back_to_back();
        t_nine();
        t_invert();
        t_gate();
        t_irq();
        t_collide();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule